// File: doc/BRIEF.md
# Power-Good Pin Aggregation Controller

This block drives the single open-drain power-good pin of a multi-rail power manager. A one-time configuration input picks one of two modes. In general-purpose mode, the pin follows one of two register bits. One bit applies in the run state and the other applies in standby. Both bits are preset from the sequencer configuration while the device is off. In power-good mode, the pin is released only when every rail enabled for monitoring is inside its voltage window. It is also held low until the sequencer signals that reset is being released.

The block also keeps a live status bit and a sticky interrupt bit for each rail, separately for overvoltage and undervoltage. It raises a power-up fault flag when a monitored rail is out of regulation at the reset-release point. The output is a pull-low enable: 1 grounds the pin and 0 lets it float high. Every output is registered.

Top module: `pg_pin_ctrl`

## Requirements
- R1: `cfg_pg_mode`=1 selects power-good mode and 0 selects general-purpose mode. The pin drive reflects the selected mode at the first clock edge after the input changes.
- R2: In general-purpose mode with `pwr_state`=2 (run), `pin_pull_low` is the inverse of the run output bit. A write with `gpo_wr`=1, `gpo_wr_sel`=0 updates that bit at one edge and reaches the pin at the next edge.
- R3: In general-purpose mode with `pwr_state`=3 (standby), `pin_pull_low` is the inverse of the standby output bit. A write with `gpo_wr_sel`=1 updates that bit.
- R4: While `pwr_state`=0 (off), both output bits are loaded with `cfg_pin_in_seq`, and writes have no effect. In general-purpose mode the pin is pulled low in the off state and in the power-up state (`pwr_state`=1).
- R5: In power-good mode, after unmasking, the pin is released only if no rail whose bit in `rail_pg_en` is 1 has an overvoltage or undervoltage flag set. Faults on rails with enable 0 have no effect on the pin.
- R6: In power-good mode with `rail_pg_en` all zero, the pin is released from the first edge at which the monitors are unmasked.
- R7: In power-good mode the pin is pulled low in the off state. It also stays low in the power-up state until `rst_release` is seen. The monitors unmask at the edge that samples `rst_release` and stay unmasked until the state returns to off.
- R8: If `rst_release` is sampled in power-good mode outside the off state while a selected rail is faulty, `pwrup_fault` is set at that edge. It is cleared by the off state.
- R9: `ov_status`/`uv_status` bit i equals the rail i overvoltage or undervoltage flag from the previous edge, for every rail whether or not it is enabled.
- R10: An interrupt bit is set by its fault flag and stays set until a 1 is written to its clear strobe. A fault in the same cycle as the clear keeps the bit set.
- R11: After reset, `pin_pull_low`=1, all status and interrupt bits are 0, `pwrup_fault`=0, the monitors are masked and both output bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pg_mode | input | 1 | 1 = power-good mode, 0 = general-purpose mode |
| cfg_pin_in_seq | input | 1 | Pin scheduled in the power-up sequence (preset value of the output bits) |
| pwr_state | input | 2 | 0 off, 1 power-up, 2 run, 3 standby |
| rst_release | input | 1 | Sequencer event: reset release point |
| rail_ov | input | NUM_RAILS | Per-rail overvoltage flags |
| rail_uv | input | NUM_RAILS | Per-rail undervoltage flags |
| rail_pg_en | input | NUM_RAILS | Per-rail enable for the power-good AND |
| gpo_wr | input | 1 | Output-bit write strobe |
| gpo_wr_sel | input | 1 | Write target: 0 run bit, 1 standby bit |
| gpo_wr_data | input | 1 | Value written |
| ov_int_clr | input | NUM_RAILS | Write-one-to-clear strobes for overvoltage interrupts |
| uv_int_clr | input | NUM_RAILS | Write-one-to-clear strobes for undervoltage interrupts |
| pin_pull_low | output | 1 | Open-drain enable: 1 grounds the pin |
| ov_status | output | NUM_RAILS | Live overvoltage status |
| uv_status | output | NUM_RAILS | Live undervoltage status |
| ov_int | output | NUM_RAILS | Sticky overvoltage interrupts |
| uv_int | output | NUM_RAILS | Sticky undervoltage interrupts |
| pwrup_fault | output | 1 | Selected rail out of regulation at reset release |

## Verification
The status, interrupt, fault flag and pin results of any change on a rail flag, the state, the mode or the release event are all due at the first edge after the inputs are sampled. A write to an output bit needs two edges to reach the pin: one to update the bit and one to register the pin. The bench drives its inputs just after an edge and updates its reference model at the next edge from those same inputs. It then compares every output a short delay after that edge, so each check falls in the cycle where its result becomes valid. A few directed checks with fixed expected values are also made at the points where unmasking, fault latching and write-one-to-clear come into play.

// File: rtl/pg_pin_pkg.sv
package pg_pin_pkg;
   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_PWRUP = 2'd1,
      PS_RUN   = 2'd2,
      PS_STBY  = 2'd3
   } pwr_state_e;

   localparam int MAX_RAILS = 32;
endpackage

// File: rtl/pg_rail_flags.sv
// Per-rail live status and sticky interrupt flags.
module pg_rail_flags #(
   parameter int NUM_RAILS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] ov_in,
   input  logic [NUM_RAILS-1:0] uv_in,
   input  logic [NUM_RAILS-1:0] ov_clr,
   input  logic [NUM_RAILS-1:0] uv_clr,
   output logic [NUM_RAILS-1:0] ov_live,
   output logic [NUM_RAILS-1:0] uv_live,
   output logic [NUM_RAILS-1:0] ov_sticky,
   output logic [NUM_RAILS-1:0] uv_sticky
);
   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ov_live[i]   <= 1'b0;
            uv_live[i]   <= 1'b0;
            ov_sticky[i] <= 1'b0;
            uv_sticky[i] <= 1'b0;
         end else begin
            ov_live[i] <= ov_in[i];
            uv_live[i] <= uv_in[i];
            // a fault in the clear cycle keeps the bit set
            if (ov_in[i])       ov_sticky[i] <= 1'b1;
            else if (ov_clr[i]) ov_sticky[i] <= 1'b0;
            if (uv_in[i])       uv_sticky[i] <= 1'b1;
            else if (uv_clr[i]) uv_sticky[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pg_gpo_regs.sv
// Run and standby output bits for general-purpose mode.
module pg_gpo_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic preload,
   input  logic preload_val,
   input  logic wr,
   input  logic wr_sel,
   input  logic wr_data,
   output logic run_bit,
   output logic stby_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_bit  <= 1'b0;
         stby_bit <= 1'b0;
      end else if (preload) begin
         run_bit  <= preload_val;
         stby_bit <= preload_val;
      end else if (wr) begin
         if (wr_sel) stby_bit <= wr_data;
         else        run_bit  <= wr_data;
      end
   end
endmodule

// File: rtl/pg_monitor_gate.sv
// Mask control, AND of the selected rails and power-up fault capture.
module pg_monitor_gate #(
   parameter int NUM_RAILS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pg_mode,
   input  logic                 in_off,
   input  logic                 release_evt,
   input  logic [NUM_RAILS-1:0] ov_in,
   input  logic [NUM_RAILS-1:0] uv_in,
   input  logic [NUM_RAILS-1:0] sel,
   output logic                 unmask_now,
   output logic                 all_good,
   output logic                 pwrup_fault
);
   logic [NUM_RAILS-1:0] rail_ok;
   logic                 unmasked_q;

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_qual
      assign rail_ok[i] = !sel[i] || !(ov_in[i] || uv_in[i]);
   end

   assign all_good   = &rail_ok;
   assign unmask_now = (unmasked_q || release_evt) && !in_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unmasked_q  <= 1'b0;
         pwrup_fault <= 1'b0;
      end else begin
         if (in_off)           unmasked_q <= 1'b0;
         else if (release_evt) unmasked_q <= 1'b1;

         if (release_evt && pg_mode && !in_off && !all_good) pwrup_fault <= 1'b1;
         else if (in_off)                                   pwrup_fault <= 1'b0;
      end
   end
endmodule

// File: rtl/pg_pin_ctrl.sv
module pg_pin_ctrl #(
   parameter int NUM_RAILS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_pg_mode,
   input  logic                 cfg_pin_in_seq,
   input  logic [1:0]           pwr_state,
   input  logic                 rst_release,
   input  logic [NUM_RAILS-1:0] rail_ov,
   input  logic [NUM_RAILS-1:0] rail_uv,
   input  logic [NUM_RAILS-1:0] rail_pg_en,
   input  logic                 gpo_wr,
   input  logic                 gpo_wr_sel,
   input  logic                 gpo_wr_data,
   input  logic [NUM_RAILS-1:0] ov_int_clr,
   input  logic [NUM_RAILS-1:0] uv_int_clr,
   output logic                 pin_pull_low,
   output logic [NUM_RAILS-1:0] ov_status,
   output logic [NUM_RAILS-1:0] uv_status,
   output logic [NUM_RAILS-1:0] ov_int,
   output logic [NUM_RAILS-1:0] uv_int,
   output logic                 pwrup_fault
);
   import pg_pin_pkg::*;

   if (NUM_RAILS < 1 || NUM_RAILS > MAX_RAILS) begin : g_bad_rails
      $error("pg_pin_ctrl: NUM_RAILS out of range");
   end

   pwr_state_e st;
   logic       in_off;
   logic       run_bit, stby_bit;
   logic       unmask_now, all_good;
   logic       gpo_level, pg_level, release_pin;

   assign st     = pwr_state_e'(pwr_state);
   assign in_off = (st == PS_OFF);

   pg_rail_flags #(.NUM_RAILS(NUM_RAILS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ov_in     (rail_ov),
      .uv_in     (rail_uv),
      .ov_clr    (ov_int_clr),
      .uv_clr    (uv_int_clr),
      .ov_live   (ov_status),
      .uv_live   (uv_status),
      .ov_sticky (ov_int),
      .uv_sticky (uv_int)
   );

   pg_gpo_regs u_gpo (
      .clk         (clk),
      .rst_n       (rst_n),
      .preload     (in_off),
      .preload_val (cfg_pin_in_seq),
      .wr          (gpo_wr),
      .wr_sel      (gpo_wr_sel),
      .wr_data     (gpo_wr_data),
      .run_bit     (run_bit),
      .stby_bit    (stby_bit)
   );

   pg_monitor_gate #(.NUM_RAILS(NUM_RAILS)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .pg_mode     (cfg_pg_mode),
      .in_off      (in_off),
      .release_evt (rst_release),
      .ov_in       (rail_ov),
      .uv_in       (rail_uv),
      .sel         (rail_pg_en),
      .unmask_now  (unmask_now),
      .all_good    (all_good),
      .pwrup_fault (pwrup_fault)
   );

   always_comb begin
      unique case (st)
         PS_RUN:  gpo_level = run_bit;
         PS_STBY: gpo_level = stby_bit;
         default: gpo_level = 1'b0;
      endcase
   end

   assign pg_level    = unmask_now && all_good;
   assign release_pin = cfg_pg_mode ? pg_level : gpo_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_pull_low <= 1'b1;
      else        pin_pull_low <= !release_pin;
   end
endmodule

// File: rtl/pg_pin_ctrl_chk.sv
module pg_pin_ctrl_chk #(
   parameter int NUM_RAILS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_pg_mode,
   input logic                 cfg_pin_in_seq,
   input logic [1:0]           pwr_state,
   input logic                 rst_release,
   input logic [NUM_RAILS-1:0] rail_ov,
   input logic [NUM_RAILS-1:0] rail_uv,
   input logic [NUM_RAILS-1:0] rail_pg_en,
   input logic                 gpo_wr,
   input logic                 gpo_wr_sel,
   input logic                 gpo_wr_data,
   input logic [NUM_RAILS-1:0] ov_int_clr,
   input logic [NUM_RAILS-1:0] uv_int_clr,
   input logic                 pin_pull_low,
   input logic [NUM_RAILS-1:0] ov_status,
   input logic [NUM_RAILS-1:0] uv_status,
   input logic [NUM_RAILS-1:0] ov_int,
   input logic [NUM_RAILS-1:0] uv_int,
   input logic                 pwrup_fault
);
   a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0) |=> pin_pull_low);

   a_r4_gpo_pwrup_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pg_mode && pwr_state == 2'd1) |=> pin_pull_low);

   a_r5_selected_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pg_mode && (((rail_ov | rail_uv) & rail_pg_en) != '0)) |=> pin_pull_low);

   a_r10_fault_sets_int: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_ov != '0) |=> ((ov_int & $past(rail_ov)) == $past(rail_ov)));

   a_r10_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((uv_int & ~uv_int_clr) != '0) |=>
         ((uv_int & $past(uv_int & ~uv_int_clr)) == $past(uv_int & ~uv_int_clr)));

   a_r8_pwrup_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_release && cfg_pg_mode && pwr_state != 2'd0 &&
       (((rail_ov | rail_uv) & rail_pg_en) != '0)) |=> pwrup_fault);
endmodule

bind pg_pin_ctrl pg_pin_ctrl_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (.*);

// File: tb/pg_pin_ctrl_bench.sv
module pg_pin_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_pg_mode = 1'b0, cfg_pin_in_seq = 1'b0;
   logic [1:0]    pwr_state = 2'd0;
   logic          rst_release = 1'b0;
   logic [NR-1:0] rail_ov = '0, rail_uv = '0, rail_pg_en = '0;
   logic          gpo_wr = 1'b0, gpo_wr_sel = 1'b0, gpo_wr_data = 1'b0;
   logic [NR-1:0] ov_int_clr = '0, uv_int_clr = '0;
   logic          pin_pull_low, pwrup_fault;
   logic [NR-1:0] ov_status, uv_status, ov_int, uv_int;

   // reference model state
   logic          m_pin, m_run, m_stby, m_unm, m_flt;
   logic [NR-1:0] m_ovs, m_uvs, m_ovi, m_uvi;

   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pg_pin_ctrl #(.NUM_RAILS(NR)) u_pg_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_pg_mode(cfg_pg_mode), .cfg_pin_in_seq(cfg_pin_in_seq),
      .pwr_state(pwr_state), .rst_release(rst_release), .rail_ov(rail_ov), .rail_uv(rail_uv),
      .rail_pg_en(rail_pg_en), .gpo_wr(gpo_wr), .gpo_wr_sel(gpo_wr_sel), .gpo_wr_data(gpo_wr_data),
      .ov_int_clr(ov_int_clr), .uv_int_clr(uv_int_clr), .pin_pull_low(pin_pull_low),
      .ov_status(ov_status), .uv_status(uv_status), .ov_int(ov_int), .uv_int(uv_int),
      .pwrup_fault(pwrup_fault));

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_pin = 1'b1; m_run = 0; m_stby = 0; m_unm = 0; m_flt = 0;
      m_ovs = '0; m_uvs = '0; m_ovi = '0; m_uvi = '0;
   endtask

   // advance one edge, update the model from the inputs seen at the edge, compare
   task automatic cyc(string pin_req);
      logic [NR-1:0] bad_sel;
      logic ok, unm_now, lvl;
      @(posedge clk);
      bad_sel = (rail_ov | rail_uv) & rail_pg_en;
      ok      = (bad_sel == '0);
      unm_now = (m_unm || rst_release) && pwr_state != 2'd0;
      if (cfg_pg_mode) lvl = unm_now && ok;
      else if (pwr_state == 2'd2) lvl = m_run;
      else if (pwr_state == 2'd3) lvl = m_stby;
      else lvl = 1'b0;
      m_pin = !lvl;
      if (rst_release && cfg_pg_mode && pwr_state != 2'd0 && !ok) m_flt = 1'b1;
      else if (pwr_state == 2'd0) m_flt = 1'b0;
      if (pwr_state == 2'd0) m_unm = 1'b0;
      else if (rst_release) m_unm = 1'b1;
      if (pwr_state == 2'd0) begin m_run = cfg_pin_in_seq; m_stby = cfg_pin_in_seq; end
      else if (gpo_wr) begin
         if (gpo_wr_sel) m_stby = gpo_wr_data; else m_run = gpo_wr_data;
      end
      for (int i = 0; i < NR; i++) begin
         if (rail_ov[i]) m_ovi[i] = 1'b1; else if (ov_int_clr[i]) m_ovi[i] = 1'b0;
         if (rail_uv[i]) m_uvi[i] = 1'b1; else if (uv_int_clr[i]) m_uvi[i] = 1'b0;
      end
      m_ovs = rail_ov; m_uvs = rail_uv;
      #2;
      chk(pin_req, pin_pull_low, m_pin);
      chk("R9 ov_status", ov_status, m_ovs);
      chk("R9 uv_status", uv_status, m_uvs);
      chk("R10 ov_int", ov_int, m_ovi);
      chk("R10 uv_int", uv_int, m_uvi);
      chk("R8 pwrup_fault", pwrup_fault, m_flt);
   endtask

   task automatic run_n(string req, int n);
      for (int k = 0; k < n; k++) cyc(req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      #(CLK_PERIOD*2 + 3);
      chk("R11 reset pin", pin_pull_low, 1'b1);
      chk("R11 reset ov_int", ov_int, '0);
      chk("R11 reset uv_status", uv_status, '0);
      chk("R11 reset fault", pwrup_fault, 1'b0);
      rst_n = 1'b1;
      run_n("R11", 2);

      // general-purpose mode, pin scheduled in sequence
      cfg_pg_mode = 0; cfg_pin_in_seq = 1;
      gpo_wr = 1; gpo_wr_sel = 0; gpo_wr_data = 0;   // ignored while off
      run_n("R4 gpo off", 3);
      gpo_wr = 0;
      pwr_state = 2'd1; run_n("R4 gpo power-up", 3);
      pwr_state = 2'd2; cyc("R2 run preload");
      chk("R2 preset run bit released", pin_pull_low, 1'b0);
      gpo_wr = 1; gpo_wr_sel = 0; gpo_wr_data = 0; cyc("R2 write");
      gpo_wr = 0; cyc("R2 write lands");
      chk("R2 run bit 0 pulls low", pin_pull_low, 1'b1);
      pwr_state = 2'd3; run_n("R3 standby", 2);
      chk("R3 standby bit preset", pin_pull_low, 1'b0);
      gpo_wr = 1; gpo_wr_sel = 1; gpo_wr_data = 0; cyc("R3 write");
      gpo_wr = 0; run_n("R3 standby low", 2);
      gpo_wr = 1; gpo_wr_data = 1; cyc("R3 write 1");
      gpo_wr = 0; run_n("R3 standby high", 2);

      // not scheduled: bits preset to 0
      pwr_state = 2'd0; cfg_pin_in_seq = 0; run_n("R4 off", 2);
      pwr_state = 2'd1; run_n("R4", 2);
      pwr_state = 2'd2; run_n("R4 run preset 0", 2);
      chk("R4 unscheduled stays low", pin_pull_low, 1'b1);

      // power-good mode
      pwr_state = 2'd0; cfg_pg_mode = 1; rail_pg_en = 4'b0101; run_n("R7 off", 2);
      pwr_state = 2'd1; run_n("R7 masked", 3);
      chk("R7 masked before release", pin_pull_low, 1'b1);
      rst_release = 1; cyc("R7 release");
      rst_release = 0;
      chk("R7 released at unmask", pin_pull_low, 1'b0);
      pwr_state = 2'd2; run_n("R5", 2);
      rail_ov = 4'b0010; run_n("R5 disabled rail ignored", 2);
      chk("R5 disabled rail fault ignored", pin_pull_low, 1'b0);
      rail_ov = 4'b0001; cyc("R5 selected ov");
      chk("R5 selected fault pulls low", pin_pull_low, 1'b1);
      rail_ov = 4'b0000; cyc("R5 recover");
      chk("R9 status cleared", ov_status, 4'b0000);
      chk("R10 int held", ov_int, 4'b0011);
      rail_ov = 4'b0001; ov_int_clr = 4'b0011; cyc("R10 clear vs fault");
      chk("R10 fault wins over clear", ov_int, 4'b0001);
      rail_ov = 0; cyc("R10");
      ov_int_clr = 4'b0001; cyc("R10 clear");
      ov_int_clr = 0;
      chk("R10 cleared", ov_int, 4'b0000);
      rail_uv = 4'b0100; run_n("R5 uv", 2);
      rail_uv = 0; uv_int_clr = 4'b1111; cyc("R10 uv clear");
      uv_int_clr = 0; cyc("R5");

      // mode switch in run
      cfg_pg_mode = 0; gpo_wr = 1; gpo_wr_sel = 0; gpo_wr_data = 1; cyc("R1 to gpo");
      gpo_wr = 0; run_n("R1 gpo run", 2);
      gpo_wr = 1; gpo_wr_data = 0; cyc("R1");
      gpo_wr = 0; cyc("R1 gpo low");
      cfg_pg_mode = 1; cyc("R1 back to pg");
      chk("R1 pg mode releases", pin_pull_low, 1'b0);

      // power-up fault at release
      pwr_state = 2'd0; run_n("R8 off", 2);
      pwr_state = 2'd1; rail_uv = 4'b0001; run_n("R8", 2);
      rst_release = 1; cyc("R8 release with fault");
      rst_release = 0;
      chk("R8 fault flagged", pwrup_fault, 1'b1);
      chk("R8 pin held low", pin_pull_low, 1'b1);
      rail_uv = 0; run_n("R8 recover", 2);
      pwr_state = 2'd0; cyc("R8 off clears");
      chk("R8 cleared in off", pwrup_fault, 1'b0);
      uv_int_clr = 4'b1111; cyc("R10"); uv_int_clr = 0;

      // no rail enabled
      rail_pg_en = 0; rail_ov = 4'b1111; pwr_state = 2'd1; run_n("R6 masked", 2);
      chk("R6 low before unmask", pin_pull_low, 1'b1);
      rst_release = 1; cyc("R6 release");
      rst_release = 0;
      chk("R6 none enabled released", pin_pull_low, 1'b0);
      chk("R6 no power-up fault", pwrup_fault, 1'b0);
      pwr_state = 2'd2; run_n("R6", 3);
      rail_ov = 0; ov_int_clr = 4'b1111; cyc("R10"); ov_int_clr = 0;
      run_n("R9", 2);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule